// File: doc/BRIEF.md
# Texture Mipmap Placement Sequencer

This block turns one 32-bit texture descriptor word plus a source byte address into an ordered stream of tile-store commands for a downstream tile writer. The texture memory is a sheet 2048 texels wide, split into two pages that are each 1024 rows high. Each command gives the destination origin on the sheet, the level's width and height, the byte address where that level's texels begin, and the texel depth. Depending on the mode field, the stream holds the full-size image, its reduced levels, or both. The reduced levels go into a fixed corner area of the sheet, not next to the full-size image.

The writer takes commands through a valid/ready handshake. Once the last command of a descriptor has been accepted, the block pulses `done` for one cycle and returns to idle. The block moves no pixel data.

Top module: `tex_mip_seq`

## Requirements
- R1: After reset, `cmd_valid` and `done` are low.
- R2: In modes 0 and 1 the first command is the full-size image. Its fields are: x = descriptor bits [5:0] times 32; y = bits [11:7] times 32, plus 1024 when bit 20 is set; width = 32 << bits [16:14]; height = 32 << bits [19:17]; address = the source base.
- R3: Descriptor bit 23 set gives `cmd_wide` = 1 and an address stride of 2 bytes per texel. Bit 23 clear gives `cmd_wide` = 0 and 1 byte per texel.
- R4: Mode code 1 (bits [27:24]) produces exactly one command, the full-size image.
- R5: Mode code 0 produces the full-size image and then reduced levels. A reduced level is produced only while the current width and height are both above 8, and each one halves both dimensions of the level before it.
- R6: Reduced level n (n = 0 for the first one) is placed at x = (2048 - 2048/2^(n+1)) + xpos/2^(n+1) and y = (1024 - 1024/2^(n+1)) + ylow/2^(n+1), plus 1024 on page 1. Here xpos and ylow are the full-size x and y before the page offset.
- R7: Each command's address is the previous command's address plus width*height*bytes-per-texel of the previous command. In mode code 2, which produces only the reduced levels, the first reduced level starts at the source base.
- R8: Any mode code other than 0, 1 or 2 produces no command, and `done` is high in the cycle after `start`.
- R9: While `cmd_valid` is high and `cmd_ready` is low, the command fields stay unchanged and `cmd_valid` stays high.
- R10: `done` goes high for exactly one cycle, in the cycle after the last command is accepted.
- R11: `start` is ignored while a descriptor is being sequenced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept `hdr_word` and `src_base` while idle |
| hdr_word | input | 32 | Texture descriptor word |
| src_base | input | ADDR_W | Byte address of the first source texel |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Writer accepts the command |
| cmd_x | output | COORD_W | Destination x origin |
| cmd_y | output | COORD_W | Destination y origin, including the page offset |
| cmd_w | output | DIM_W | Level width in texels |
| cmd_h | output | DIM_W | Level height in texels |
| cmd_addr | output | ADDR_W | Source byte address of the level |
| cmd_wide | output | 1 | 1 for 16-bit texels, 0 for 8-bit texels |
| done | output | 1 | One-cycle pulse after the final command |

## Verification
The bench builds the block with its default parameters: a sheet 2048 wide, pages 1024 high, 32-bit addresses and nine placement levels. With these values a 4096x4096 descriptor walks all nine reduced levels down to the smallest corner slot, so the deepest shift in the placement arithmetic is exercised. A non-square descriptor stops the level walk early. A descriptor at the right and bottom edge of page 1 checks that no coordinate overflows.

// File: rtl/tex_mip_pkg.sv
// Shared types and field codes for the texture placement sequencer.
// Assumes the descriptor layout documented in the brief.
package tex_mip_pkg;
    localparam int TILE_LG = 5;   // tile origin and minimum size are 2^5
    localparam int MIN_LG  = 3;   // levels stop once a side reaches 2^3

    localparam logic [3:0] MODE_FULL = 4'd0;
    localparam logic [3:0] MODE_BASE = 4'd1;
    localparam logic [3:0] MODE_MIPS = 4'd2;

    typedef struct packed {
        logic [3:0] mode;
        logic       wide;
        logic       page;
        logic [2:0] hcode;
        logic [2:0] wcode;
        logic [4:0] ytile;
        logic [5:0] xtile;
    } tex_hdr_t;

    typedef enum logic [1:0] {S_IDLE, S_EMIT, S_FIN} seq_state_t;
endpackage

// File: rtl/tex_hdr_decode.sv
// Splits a descriptor word into its fields. Purely combinational.
// Assumes bit positions fixed by the descriptor format.
module tex_hdr_decode
    import tex_mip_pkg::*;
(
    input  logic [31:0] hdr_word,
    output tex_hdr_t    fields
);
    // field extraction
    always_comb begin
        fields.xtile = hdr_word[5:0];
        fields.ytile = hdr_word[11:7];
        fields.wcode = hdr_word[16:14];
        fields.hcode = hdr_word[19:17];
        fields.page  = hdr_word[20];
        fields.wide  = hdr_word[23];
        fields.mode  = hdr_word[27:24];
    end
endmodule

// File: rtl/tex_mip_place.sv
// Computes the destination origin for the full-size image or for a
// reduced level. Assumes lvl stays below the number of corner slots.
module tex_mip_place #(
    parameter int COORD_W = 12,
    parameter int SHEET_W = 2048,
    parameter int PAGE_H  = 1024,
    parameter int LVL_W   = 4
) (
    input  logic [LVL_W-1:0]   lvl,
    input  logic               is_mip,
    input  logic               page,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    output logic [COORD_W-1:0] pos_x,
    output logic [COORD_W-1:0] pos_y
);
    localparam logic [COORD_W-1:0] SHEET_C = COORD_W'(SHEET_W);
    localparam logic [COORD_W-1:0] PAGE_C  = COORD_W'(PAGE_H);

    logic [LVL_W:0]       shamt;
    logic [COORD_W-1:0]   y_lane;

    assign shamt = (LVL_W+1)'(lvl) + (LVL_W+1)'(1);

    // corner-slot offset plus scaled origin, or the plain origin
    always_comb begin
        if (is_mip) begin
            pos_x  = SHEET_C - (SHEET_C >> shamt) + (org_x >> shamt);
            y_lane = PAGE_C - (PAGE_C >> shamt) + (org_y >> shamt);
        end else begin
            pos_x  = org_x;
            y_lane = org_y;
        end
        pos_y = y_lane + (page ? PAGE_C : '0);
    end
endmodule

// File: rtl/tex_mip_seq.sv
// Top: latches a descriptor on start and steps through the full-size
// image and the reduced levels, one command per handshake.
// Assumes cmd_ready may stall at any time; start is honoured only when idle.
module tex_mip_seq
    import tex_mip_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SHEET_W = 2048,
    parameter int PAGE_H  = 1024,
    parameter int MAX_LVL = 9,
    localparam int COORD_W = $clog2(SHEET_W) + 1,
    localparam int DIM_W   = TILE_LG + 8,
    localparam int LVL_W   = $clog2(MAX_LVL + 1),
    localparam int LG_W    = $clog2(DIM_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [31:0]        hdr_word,
    input  logic [ADDR_W-1:0]  src_base,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [COORD_W-1:0] cmd_x,
    output logic [COORD_W-1:0] cmd_y,
    output logic [DIM_W-1:0]   cmd_w,
    output logic [DIM_W-1:0]   cmd_h,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic               cmd_wide,
    output logic               done
);
    seq_state_t         st;
    tex_hdr_t           dec, f_q;
    logic               at_base;
    logic [LVL_W-1:0]   lvl;
    logic [LG_W-1:0]    lg_w, lg_h;
    logic [ADDR_W-1:0]  cur_addr;
    logic [LG_W+1:0]    area_lg;
    logic               can_halve, fire, busy;
    logic [COORD_W-1:0] org_x, org_y;

    tex_hdr_decode u_dec (.hdr_word(hdr_word), .fields(dec));

    assign org_x = COORD_W'(f_q.xtile) << TILE_LG;
    assign org_y = COORD_W'(f_q.ytile) << TILE_LG;

    tex_mip_place #(
        .COORD_W(COORD_W), .SHEET_W(SHEET_W), .PAGE_H(PAGE_H), .LVL_W(LVL_W)
    ) u_place (
        .lvl(lvl), .is_mip(!at_base), .page(f_q.page),
        .org_x(org_x), .org_y(org_y), .pos_x(cmd_x), .pos_y(cmd_y)
    );

    // size bookkeeping for the level on offer
    assign area_lg   = (LG_W+2)'(lg_w) + (LG_W+2)'(lg_h) + (LG_W+2)'(f_q.wide);
    assign can_halve = (lg_w > LG_W'(MIN_LG)) && (lg_h > LG_W'(MIN_LG))
                       && (at_base || (lvl < LVL_W'(MAX_LVL - 1)));
    assign fire      = cmd_valid && cmd_ready;
    assign busy      = (st != S_IDLE);

    // command outputs from the held state
    assign cmd_valid = (st == S_EMIT);
    assign cmd_w     = DIM_W'(1) << lg_w;
    assign cmd_h     = DIM_W'(1) << lg_h;
    assign cmd_addr  = cur_addr;
    assign cmd_wide  = f_q.wide;
    assign done      = (st == S_FIN);

    // sequencing of levels, addresses and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            f_q      <= '0;
            at_base  <= 1'b0;
            lvl      <= '0;
            lg_w     <= '0;
            lg_h     <= '0;
            cur_addr <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    f_q      <= dec;
                    lvl      <= '0;
                    cur_addr <= src_base;
                    if (dec.mode == MODE_FULL || dec.mode == MODE_BASE) begin
                        at_base <= 1'b1;
                        lg_w    <= LG_W'(TILE_LG) + LG_W'(dec.wcode);
                        lg_h    <= LG_W'(TILE_LG) + LG_W'(dec.hcode);
                        st      <= S_EMIT;
                    end else if (dec.mode == MODE_MIPS) begin
                        at_base <= 1'b0;
                        lg_w    <= LG_W'(TILE_LG - 1) + LG_W'(dec.wcode);
                        lg_h    <= LG_W'(TILE_LG - 1) + LG_W'(dec.hcode);
                        st      <= S_EMIT;
                    end else begin
                        st <= S_FIN;
                    end
                end
                S_EMIT: if (fire) begin
                    cur_addr <= cur_addr + (ADDR_W'(1) << area_lg);
                    if (!at_base) lvl <= lvl + LVL_W'(1);
                    if (can_halve && (!at_base || f_q.mode == MODE_FULL)) begin
                        at_base <= 1'b0;
                        lg_w    <= lg_w - LG_W'(1);
                        lg_h    <= lg_h - LG_W'(1);
                    end else begin
                        st <= S_FIN;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tex_mip_seq_chk.sv
// Protocol and stepping checks for tex_mip_seq, attached by bind.
module tex_mip_seq_chk #(
    parameter int ADDR_W  = 32,
    parameter int COORD_W = 12,
    parameter int DIM_W   = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic [31:0]        hdr_word,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic [COORD_W-1:0] cmd_x,
    input logic [COORD_W-1:0] cmd_y,
    input logic [DIM_W-1:0]   cmd_w,
    input logic [DIM_W-1:0]   cmd_h,
    input logic [ADDR_W-1:0]  cmd_addr,
    input logic               cmd_wide,
    input logic               done
);
    logic [ADDR_W-1:0] step;
    assign step = (ADDR_W'(cmd_w) * ADDR_W'(cmd_h)) << cmd_wide;

    AST_BAD_MODE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (hdr_word[27:24] > 4'd2) |=> done && !cmd_valid); // R8

    AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_x) && $stable(cmd_y)
            && $stable(cmd_w) && $stable(cmd_h) && $stable(cmd_addr)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !cmd_valid); // R10

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_valid
            || (cmd_addr == $past(cmd_addr) + $past(step))); // R7

    AST_LEVEL_HALVE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_valid
            || (cmd_w == ($past(cmd_w) >> 1) && cmd_h == ($past(cmd_h) >> 1))); // R5

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && cmd_valid)); // R10
endmodule

bind tex_mip_seq tex_mip_seq_chk #(
    .ADDR_W(ADDR_W), .COORD_W(COORD_W), .DIM_W(DIM_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .hdr_word(hdr_word),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_x(cmd_x), .cmd_y(cmd_y),
    .cmd_w(cmd_w), .cmd_h(cmd_h), .cmd_addr(cmd_addr), .cmd_wide(cmd_wide),
    .done(done)
);

// File: tb/tex_mip_seq_tb_top.sv
module tex_mip_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] hdr_word = '0;
    logic [31:0] src_base = '0;
    logic        cmd_ready = 1'b0;
    logic        cmd_valid, cmd_wide, done;
    logic [11:0] cmd_x, cmd_y;
    logic [12:0] cmd_w, cmd_h;
    logic [31:0] cmd_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [82:0] expq [0:15];
    int          exp_n;

    always #2 clk = ~clk;

    tex_mip_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .hdr_word(hdr_word),
        .src_base(src_base), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_w(cmd_w), .cmd_h(cmd_h),
        .cmd_addr(cmd_addr), .cmd_wide(cmd_wide), .done(done)
    );

    function automatic logic [31:0] mk_hdr(input logic [3:0] mode, input logic wide,
        input logic page, input logic [2:0] hc, input logic [2:0] wc,
        input logic [4:0] yt, input logic [5:0] xt);
        return {4'h0, mode, wide, 2'b00, page, hc, wc, 2'b00, yt, 1'b0, xt};
    endfunction

    task automatic check(input string req, input logic [82:0] got, input logic [82:0] expv);
        total++;
        if (got !== expv) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, expv);
        end
    endtask

    // expected command list from the requirement formulas
    task automatic build_exp(input logic [31:0] h, input logic [31:0] base);
        int lw = 5 + int'(h[16:14]);
        int lh = 5 + int'(h[19:17]);
        int xp = int'(h[5:0]) * 32;
        int yl = int'(h[11:7]) * 32;
        int pg = int'(h[20]) * 1024;
        int bpp = h[23] ? 2 : 1;
        int md = int'(h[27:24]);
        longint a = base;
        exp_n = 0;
        if (md == 0 || md == 1) begin
            expq[exp_n] = {12'(xp), 12'(yl + pg), 13'(1 << lw), 13'(1 << lh), 32'(a), h[23]};
            exp_n++;
            a += (longint'(1) << (lw + lh)) * bpp;
        end
        if (md == 0 || md == 2) begin
            for (int lv = 0; lw > 3 && lh > 3; lv++) begin
                int xt = 0;
                int ytb = 0;
                int dv = 2 << lv;
                for (int k = 0; k <= lv; k++) begin
                    xt += 1024 >> k;
                    ytb += 512 >> k;
                end
                lw--; lh--;
                expq[exp_n] = {12'(xt + xp / dv), 12'(ytb + yl / dv + pg),
                               13'(1 << lw), 13'(1 << lh), 32'(a), h[23]};
                exp_n++;
                a += (longint'(1) << (lw + lh)) * bpp;
            end
        end
    endtask

    // one descriptor: drive, collect, compare, check completion timing
    task automatic run_case(input string req, input logic [31:0] h, input logic [31:0] base,
                            input bit stall, input bit poke);
        int got_n = 0;
        int last_fire = -1;
        int done_cyc = -1;
        bit hold_pend = 0;
        logic [82:0] held = '0;
        logic [82:0] cur;
        build_exp(h, base);
        @(negedge clk);
        start = 1'b1; hdr_word = h; src_base = base;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            start = 1'b1; hdr_word = 32'h0500_0000; src_base = 32'hDEAD_0000;
        end
        for (int c = 0; c < 400; c++) begin
            if (c > 0) @(negedge clk);
            if (c == 1) start = 1'b0;
            cur = {cmd_x, cmd_y, cmd_w, cmd_h, cmd_addr, cmd_wide};
            if (hold_pend) begin
                check("R9 hold while stalled", {cur[82:1], cmd_valid}, {held[82:1], 1'b1});
                hold_pend = 0;
            end
            if (done) begin done_cyc = c; break; end
            cmd_ready = stall ? (c % 3 != 1) : 1'b1;
            if (cmd_valid) begin
                if (cmd_ready) begin
                    if (got_n < exp_n)
                        check({req, " command fields"}, cur, expq[got_n]);
                    got_n++;
                    last_fire = c;
                end else begin
                    held = cur; hold_pend = 1;
                end
            end
        end
        check({req, " R11 command count"}, 83'(got_n), 83'(exp_n));
        if (exp_n == 0)
            check("R8 done right after start", 83'(done_cyc), 83'(0));
        else
            check("R10 done after last accept", 83'(done_cyc), 83'(last_fire + 1));
        @(negedge clk);
        check("R10 done single cycle", {81'b0, done, cmd_valid}, 83'b0);
        cmd_ready = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {81'b0, cmd_valid, done}, 83'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {81'b0, cmd_valid, done}, 83'b0);
    endtask

    initial begin
        t_reset();
        // R2 R3 R4: base only, 16-bit, page 1
        run_case("R2 R3 R4 base only", mk_hdr(4'd1, 1'b1, 1'b1, 3'd1, 3'd2, 5'd3, 6'd5),
                 32'h0000_1000, 0, 0);
        // R5 R6 R7: smallest full chain, 8-bit
        run_case("R5 R6 R7 full 32x32", mk_hdr(4'd0, 1'b0, 1'b0, 3'd0, 3'd0, 5'd1, 6'd2),
                 32'h0004_0000, 0, 0);
        // R6: deepest chain, edge origin, page 1, 16-bit
        run_case("R6 R3 full 4096x4096", mk_hdr(4'd0, 1'b1, 1'b1, 3'd7, 3'd7, 5'd31, 6'd63),
                 32'h0100_0000, 0, 0);
        // R7 R9: reduced levels only with stalls
        run_case("R7 R9 mips only", mk_hdr(4'd2, 1'b1, 1'b0, 3'd2, 3'd1, 5'd8, 6'd16),
                 32'h0020_0000, 1, 0);
        // R8: unrecognised mode
        run_case("R8 bad mode", mk_hdr(4'd5, 1'b0, 1'b0, 3'd1, 3'd1, 5'd0, 6'd0),
                 32'h0000_0000, 0, 0);
        // R5 R11: non-square chain with a start pulse while busy
        run_case("R5 R11 256x32 busy start", mk_hdr(4'd0, 1'b0, 1'b1, 3'd0, 3'd3, 5'd12, 6'd40),
                 32'h0003_0000, 1, 1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #600000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule